// File: doc/BRIEF.md
# Auxiliary UART Register Front End

This block is the bus-facing half of a small auxiliary UART. It sits on a 32-bit word bus with single-cycle accesses and keeps received bytes in a circular buffer. Software reads them through a data register and learns the state of the UART through several status and identify views.

Bytes from the receive path arrive on a valid/ready pair. A byte is taken only while the buffer has room. A write to the data register sends its low byte straight out on a one-cycle transmit strobe, so the transmitter always counts as empty. A level interrupt reflects two sources, each with its own enable: receive data is waiting, and the transmitter is empty.

Baud generation, serial framing, modem lines, the scratch location and any second serial function are not part of this block. Their registers read as zero and ignore writes.

Bus addresses are byte addresses. Bits 1:0 are ignored, and bits 7:2 select the register. Read data appears on `bus_rdata` one clock after the read is presented and holds until the next read.

Top module: `aux_uart_regs`

## Requirements
- R1: After reset the buffer is empty and the interrupt enables are zero. `irq` is low, `rx_ready` is high and `tx_strobe` is low.
- R2: A byte on `rx_valid` is stored only while fewer than DEPTH (8) bytes are held. `rx_ready` is low exactly when DEPTH bytes are held, and bytes offered then are dropped.
- R3: A read of offset 0x40 returns the oldest held byte in bits 7:0 and removes it. Bytes come out in arrival order across the wrap of the circular buffer.
- R4: A read of offset 0x40 while the buffer is empty removes nothing, and the fill stays zero.
- R5: A write to offset 0x44 stores only data bits 1:0: bit 0 enables receive interrupts and bit 1 enables transmit interrupts. A read returns 0xC0 ORed with the stored bits.
- R6: `irq` is high exactly when bit 0 of the enables is set and the buffer holds data, or when bit 1 of the enables is set.
- R7: A read of offset 0x48 returns 0xC0, plus 0x4 if the buffer holds data and 0x2 if it does not, plus 0x1 when `irq` is low.
- R8: A write to offset 0x48 with data bit 1 set empties the buffer, and a byte offered in the same cycle is dropped. A write with bit 1 clear changes nothing.
- R9: A read of offset 0x54 returns 0x60, with bit 0 set when the buffer holds data.
- R10: A read of offset 0x64 returns 0x30E. When the buffer holds data it also sets bit 0 and places the fill count in bits 19:16.
- R11: A write to offset 0x40 raises `tx_strobe` for one cycle after the write edge, with `tx_byte` equal to data bits 7:0. Back-to-back writes give back-to-back strobes.
- R12: Offset 0x00 reads 1 while `irq` is high and 0 otherwise. Offset 0x04 reads 1 and offset 0x60 reads 3.
- R13: Every other offset, including 0x4C, 0x50, 0x58, 0x5C and 0x68, reads zero. A write to any offset other than 0x40, 0x44 and 0x48 changes no state.
- R14: In a cycle with both a data-register read and an accepted byte, the fill stays the same and the new byte queues behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Room for a byte |
| tx_strobe | output | 1 | Transmit byte valid for one cycle |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets these corner cases:
- Filling the buffer to its limit while a byte keeps being offered. A design that compares the fill against DEPTH-1, or that forgets the full state, would drop or overwrite data.
- Draining across the pointer wrap, which exposes a design that computes the store slot modulo the wrong value.
- A push and a pop in the same cycle. A design that lets one side win would change the fill.
- A flush with a byte arriving in the same cycle, and a data read on an empty buffer. A wrong design would leave a byte behind or drive the fill below zero.
- The identify and extended-status encodings in each combination of enables and fill. A misplaced bit shows up directly in the read value.

// File: rtl/aux_uart_pkg.sv
package aux_uart_pkg;
  // register word indices (byte offset >> 2)
  localparam logic [5:0] WI_SUMMARY = 6'h00;
  localparam logic [5:0] WI_ENABLE  = 6'h01;
  localparam logic [5:0] WI_DATA    = 6'h10;
  localparam logic [5:0] WI_IEN     = 6'h11;
  localparam logic [5:0] WI_IDENT   = 6'h12;
  localparam logic [5:0] WI_LSTAT   = 6'h15;
  localparam logic [5:0] WI_CTRL    = 6'h18;
  localparam logic [5:0] WI_XSTAT   = 6'h19;

  localparam logic [31:0] FIFO_ON_BITS = 32'h0000_00C0;
  localparam logic [31:0] LSTAT_BASE   = 32'h0000_0060;
  localparam logic [31:0] XSTAT_BASE   = 32'h0000_030E;
  localparam int          XSTAT_FILL_LSB = 16;
  localparam logic [31:0] CTRL_VALUE   = 32'h0000_0003;
  localparam logic [31:0] ENABLE_VALUE = 32'h0000_0001;
endpackage

// File: rtl/aux_uart_rxq.sv
module aux_uart_rxq #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              flush,
  output logic              ready,
  output logic [CW-1:0]     fill,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     rd_ptr;
  logic [CW:0]       slot_sum;
  logic [PW-1:0]     wr_idx;
  logic              do_push, do_pop;

  assign ready   = (fill < CW'(DEPTH));
  assign do_push = push_req && ready && !flush;
  assign do_pop  = pop_req && (fill != '0) && !flush;

  // store slot = read pointer + fill, folded into [0, DEPTH)
  assign slot_sum = (CW+1)'(rd_ptr) + (CW+1)'(fill);
  assign wr_idx   = (slot_sum >= (CW+1)'(DEPTH)) ? PW'(slot_sum - (CW+1)'(DEPTH))
                                                 : PW'(slot_sum);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      fill   <= '0;
    end else if (flush) begin
      fill <= '0;
    end else begin
      if (do_pop) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/aux_uart_rdmux.sv
module aux_uart_rdmux
  import aux_uart_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [5:0]    word_idx,
  input  logic [1:0]    ien,
  input  logic [CW-1:0] fill,
  input  logic          irq_level,
  input  logic [7:0]    head,
  output logic [31:0]   rd_value
);
  logic has_data;
  assign has_data = (fill != '0);

  always_comb begin
    rd_value = '0;
    case (word_idx)
      WI_SUMMARY: rd_value = {31'd0, irq_level};
      WI_ENABLE:  rd_value = ENABLE_VALUE;
      WI_DATA:    rd_value = {24'd0, head};
      WI_IEN:     rd_value = FIFO_ON_BITS | {30'd0, ien};
      WI_IDENT:   rd_value = FIFO_ON_BITS | (has_data ? 32'h4 : 32'h2) |
                             {31'd0, !irq_level};
      WI_LSTAT:   rd_value = LSTAT_BASE | {31'd0, has_data};
      WI_CTRL:    rd_value = CTRL_VALUE;
      WI_XSTAT:   rd_value = has_data ? (XSTAT_BASE | 32'h1 |
                                         (32'(fill) << XSTAT_FILL_LSB))
                                      : XSTAT_BASE;
      default:    rd_value = '0;
    endcase
  end
endmodule

// File: rtl/aux_uart_regs.sv
module aux_uart_regs
  import aux_uart_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        rx_ready,
  output logic        tx_strobe,
  output logic [7:0]  tx_byte,
  output logic        irq
);
  logic [5:0]    word_idx;
  logic          rd_en, wr_en;
  logic [1:0]    ien;
  logic [CW-1:0] fill;
  logic [7:0]    head;
  logic [31:0]   rd_value;
  logic          pop_req, flush;
  logic          unused_bits;

  assign word_idx    = bus_addr[7:2];
  assign rd_en       = bus_sel && !bus_wr;
  assign wr_en       = bus_sel && bus_wr;
  assign pop_req     = rd_en && (word_idx == WI_DATA);
  assign flush       = wr_en && (word_idx == WI_IDENT) && bus_wdata[1];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:8]};

  aux_uart_rxq #(.DEPTH(DEPTH), .DATA_W(8)) u_rxq (
    .clk      (clk),
    .rst      (rst),
    .push_req (rx_valid),
    .push_data(rx_byte),
    .pop_req  (pop_req),
    .flush    (flush),
    .ready    (rx_ready),
    .fill     (fill),
    .head     (head)
  );

  assign irq = (ien[0] && (fill != '0)) || ien[1];

  aux_uart_rdmux #(.CW(CW)) u_rdmux (
    .word_idx (word_idx),
    .ien      (ien),
    .fill     (fill),
    .irq_level(irq),
    .head     (head),
    .rd_value (rd_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ien       <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
      bus_rdata <= '0;
    end else begin
      tx_strobe <= wr_en && (word_idx == WI_DATA);
      if (wr_en && (word_idx == WI_DATA)) tx_byte <= bus_wdata[7:0];
      if (wr_en && (word_idx == WI_IEN))  ien <= bus_wdata[1:0];
      if (rd_en) bus_rdata <= rd_value;
    end
  end
endmodule

// File: rtl/aux_uart_regs_chk.sv
module aux_uart_regs_chk
  import aux_uart_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [7:0]    bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          tx_strobe,
  input logic [7:0]    tx_byte,
  input logic [CW-1:0] fill
);
  logic data_wr, data_rd, flush_wr, other_wr;
  assign data_wr  = bus_sel && bus_wr && (bus_addr[7:2] == WI_DATA);
  assign data_rd  = bus_sel && !bus_wr && (bus_addr[7:2] == WI_DATA);
  assign flush_wr = bus_sel && bus_wr && (bus_addr[7:2] == WI_IDENT) && bus_wdata[1];
  assign other_wr = flush_wr || data_rd;

  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (fill == '0) && !tx_strobe);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  a_r2_accept_grows: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && !other_wr) |=> fill == $past(fill) + 1'b1);

  a_r4_empty_read: assert property (@(posedge clk) disable iff (rst)
    (data_rd && (fill == '0) && !rx_valid) |=> fill == '0);

  a_r8_flush: assert property (@(posedge clk) disable iff (rst)
    flush_wr |=> fill == '0);

  a_r11_strobe: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> tx_strobe && (tx_byte == $past(bus_wdata[7:0])));

  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> !tx_strobe);
endmodule

bind aux_uart_regs aux_uart_regs_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .fill(fill)
);

// File: tb/aux_uart_regs_test.sv
module aux_uart_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  byte unsigned q[$];
  int           m_ien = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_uart_regs #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit m_irq();
    return ((m_ien & 1) != 0 && q.size() > 0) || ((m_ien & 2) != 0);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] v;
    bit nz = q.size() > 0;
    case (a[7:2])
      6'h00: v = {31'd0, m_irq()};
      6'h01: v = 32'h1;
      6'h10: v = nz ? {24'd0, q[0]} : 32'h0;
      6'h11: v = 32'hC0 | m_ien;
      6'h12: v = 32'hC0 | (nz ? 32'h4 : 32'h2) | (m_irq() ? 32'h0 : 32'h1);
      6'h15: v = 32'h60 | {31'd0, nz};
      6'h18: v = 32'h3;
      6'h19: v = nz ? (32'h30F | (q.size() << 16)) : 32'h30E;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  // one bus/rx cycle, model update and per-clock comparison
  task automatic cyc(bit sel, bit wr, logic [7:0] a, logic [31:0] wd,
                     bit rv, logic [7:0] rb, string tag);
    logic [31:0] exp_rd;
    bit is_rd, chk_rd, pre_ready, exp_tx;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rv; rx_byte = rb;
    is_rd     = sel && !wr;
    exp_rd    = m_read(a);
    chk_rd    = is_rd && !(a[7:2] == 6'h10 && q.size() == 0);
    pre_ready = q.size() < DEPTH;
    exp_tx    = sel && wr && a[7:2] == 6'h10;
    @(posedge clk);
    if (sel && wr && a[7:2] == 6'h12 && wd[1]) begin
      q.delete();
    end else begin
      if (is_rd && a[7:2] == 6'h10 && q.size() > 0) void'(q.pop_front());
      if (rv && pre_ready) q.push_back(rb);
    end
    if (sel && wr && a[7:2] == 6'h11) m_ien = int'(wd & 32'h3);
    #1;
    if (chk_rd) chk(tag, bus_rdata, exp_rd);
    chk("R6 irq", {31'd0, irq}, {31'd0, m_irq()});
    chk("R2 rx_ready", {31'd0, rx_ready}, {31'd0, q.size() < DEPTH});
    chk("R11 tx_strobe", {31'd0, tx_strobe}, {31'd0, exp_tx});
    if (exp_tx) chk("R11 tx_byte", {24'd0, tx_byte}, {24'd0, wd[7:0]});
  endtask

  task automatic rd(logic [7:0] a, string tag); cyc(1, 0, a, 0, 0, 0, tag); endtask
  task automatic wr(logic [7:0] a, logic [31:0] d, string tag); cyc(1, 1, a, d, 0, 0, tag); endtask
  task automatic push(logic [7:0] b, string tag); cyc(0, 0, 0, 0, 1, b, tag); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state at the ports
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    chk("R1 tx_strobe", {31'd0, tx_strobe}, 32'd0);
    rd(8'h44, "R1 R5 ien");
    rd(8'h64, "R1 R10 xstat empty");
    rd(8'h48, "R7 ident empty");
    rd(8'h54, "R9 lstat empty");
    rd(8'h00, "R12 summary");
    rd(8'h04, "R12 enables");
    rd(8'h60, "R12 ctrl");

    // three bytes in, status views
    for (int i = 0; i < 3; i++) push(8'(8'h41 + i), "R2 push");
    rd(8'h64, "R10 xstat fill3");
    rd(8'h54, "R9 lstat data");
    rd(8'h48, "R7 ident data no irq");
    wr(8'h44, 32'hFFFF_FFFD, "R5 ien write");
    rd(8'h44, "R5 ien mask");
    rd(8'h48, "R7 ident data irq");
    rd(8'h00, "R12 summary irq");
    for (int i = 0; i < 3; i++) rd(8'h40, "R3 pop order");
    rd(8'h48, "R7 ident empty rx-only");
    // R4: empty read
    rd(8'h40, "R4 empty read");
    rd(8'h64, "R4 still empty");

    // R2: fill past limit, bytes offered while full are dropped
    for (int i = 0; i < 11; i++) push(8'(8'h90 + i*7), "R2 fill");
    rd(8'h64, "R2 R10 full count");
    // full: read + offered byte, byte dropped
    cyc(1, 0, 8'h40, 0, 1, 8'hEE, "R2 R3 full pop");
    // R14: push and pop together at partial fill
    cyc(1, 0, 8'h40, 0, 1, 8'h5A, "R14 pop+push");
    rd(8'h64, "R14 fill kept");
    // drain across wrap
    for (int i = 0; i < 8; i++) rd(8'h40, "R3 wrap drain");
    rd(8'h54, "R9 drained");

    // R8: flush with a concurrent byte, then a no-op identify write
    for (int i = 0; i < 5; i++) push(8'(8'h20 + i), "R8 prefill");
    cyc(1, 1, 8'h48, 32'h4, 1, 8'h77, "R8 no flush");
    rd(8'h64, "R8 kept");
    cyc(1, 1, 8'h48, 32'h2, 1, 8'hAA, "R8 flush");
    rd(8'h64, "R8 emptied");
    push(8'h3C, "R8 after flush");
    rd(8'h40, "R8 R3 after flush");

    // R11: transmit strobes
    wr(8'h40, 32'h1234_56A5, "R11 tx1");
    wr(8'h40, 32'h0000_0017, "R11 tx2");
    cyc(0, 0, 0, 0, 0, 0, "R11 idle");

    // R13: unmapped and unimplemented offsets
    wr(8'h44, 32'h2, "R6 tx only");
    push(8'h66, "R13 prefill");
    wr(8'h5C, 32'hFFFF_FFFF, "R13 scratch wr");
    wr(8'h00, 32'h0, "R13 summary wr");
    wr(8'h04, 32'h0, "R13 enables wr");
    wr(8'h60, 32'h0, "R13 ctrl wr");
    wr(8'h4C, 32'hFF, "R13 lcr wr");
    wr(8'hA0, 32'hFF, "R13 hole wr");
    rd(8'h5C, "R13 scratch rd");
    rd(8'h4C, "R13 lcr rd");
    rd(8'h50, "R13 mcr rd");
    rd(8'h58, "R13 msr rd");
    rd(8'h68, "R13 baud rd");
    rd(8'hA0, "R13 hole rd");
    rd(8'h44, "R13 ien kept");
    rd(8'h64, "R13 fifo kept");
    rd(8'h42, "R3 R13 low addr bits ignored");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule